// File: doc/BRIEF.md
# Command-Port Watchdog Timer

This block is a system watchdog that a host drives through two byte-wide port registers in a two-byte window. The data port is at offset 0 and the command port at offset 1. A byte written to the command port selects an action: identify the block, begin an indirect register write, start the watchdog, stop it, or refresh it. The indirect write takes two further data-port bytes, an index and then a value. The value goes into one byte of one of two 16-bit delay settings.

Once started, a prescaler divides the clock into 100 ms ticks. The block first counts the arming (enable) delay. If that delay is zero, this phase is skipped. It then counts the reset delay. If the host does not refresh in time, the countdown expires and the block drives a system reset pulse of fixed length. After the pulse it falls back to the stopped state.

Every byte is decoded in the clock cycle it arrives in. A host that leaves several milliseconds between accesses can therefore never overrun the decoder.

Top module: `portWatchdog`

## Requirements
- R1: Writing 0x30 to the command port makes the next data-port read return 0x95. Every other data-port read, including a second read after the probe, returns 0x00.
- R2: Command 0x89 starts an indirect write. The next data-port byte is the index and the byte after it is the value. Index 0x58 is the high byte and 0x59 the low byte of the arming delay. Index 0x5E is the high byte and 0x5F the low byte of the reset delay. Both bytes of each 16-bit delay take effect.
- R3: Command 0x28 issued while stopped, with an arming delay of zero and a reset delay N, asserts sysReset N×TICK_CYCLES clock edges after the edge that takes the command. A reset delay of 0 behaves as 1.
- R4: With an arming delay A greater than zero, sysReset asserts (A+N)×TICK_CYCLES edges after the start edge.
- R5: Command 0x2A during the reset countdown reloads the reset delay and clears the prescaler, so sysReset asserts N×TICK_CYCLES edges after the refresh edge.
- R6: Command 0x29 during either timing phase returns the block to stopped, and no reset follows.
- R7: sysReset stays high for exactly PULSE_CYCLES cycles. The block is then stopped, and no further pulse follows without a new start.
- R8: A command byte written between the index and value of an indirect write abandons that write. A data byte written afterwards changes nothing.
- R9: Unknown command bytes, and indirect writes to unknown indices, have no effect on delays or timing.
- R10: Stop and refresh while stopped have no effect. Delay settings are kept across stop and start.
- R11: After reset, sysReset is low, the block is stopped, the arming delay is 0 and the reset delay is DEFAULT_RST_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | Port select: 0 data, 1 command |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte, valid while busRd is high |
| sysReset | output | 1 | System reset pulse |

## Verification
The bench builds the block with TICK_CYCLES=4, PULSE_CYCLES=3 and DEFAULT_RST_TICKS=3. With these values a whole timing sequence takes only tens of cycles. That makes it practical to sweep arming delays 0 to 2 against reset delays 0 to 4 and measure the edge-exact latency and pulse width of every combination. The short tick also keeps a reset delay of 258 ticks within reach, which shows the high byte taking effect. Refresh, stop, abandoned writes and ignored bytes are each checked against latencies the bench computes arithmetically.

// File: rtl/portWdtPkg.sv
package portWdtPkg;
  localparam logic [7:0] CMD_PROBE    = 8'h30;
  localparam logic [7:0] CMD_INDIRECT = 8'h89;
  localparam logic [7:0] CMD_START    = 8'h28;
  localparam logic [7:0] CMD_STOP     = 8'h29;
  localparam logic [7:0] CMD_REFRESH  = 8'h2A;
  localparam logic [7:0] IDX_ARM_HI   = 8'h58;
  localparam logic [7:0] IDX_ARM_LO   = 8'h59;
  localparam logic [7:0] IDX_RST_HI   = 8'h5E;
  localparam logic [7:0] IDX_RST_LO   = 8'h5F;
  localparam logic [7:0] ID_VALUE     = 8'h95;

  typedef enum logic [1:0] {
    PH_STOPPED,
    PH_ARMING,
    PH_COUNTING,
    PH_FIRING
  } wdtPhase_t;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       refresh;
    logic       regWr;
    logic [7:0] regIdx;
    logic [7:0] regData;
  } wdtStrobes_t;
endpackage

// File: rtl/portWdtCtrl.sv
module portWdtCtrl
  import portWdtPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  output wdtStrobes_t strobes
);
  typedef enum logic [1:0] {DEC_IDLE, DEC_WAIT_IDX, DEC_WAIT_DATA} decState_t;

  decState_t  decState;
  logic [7:0] idxReg;
  logic       probeFlag;
  logic       cmdWr;
  logic       dataWr;
  logic       dataRd;

  assign cmdWr  = busWr && busAddr;
  assign dataWr = busWr && !busAddr;
  assign dataRd = busRd && !busAddr;

  // command decode: strobes are valid in the cycle the byte arrives
  always_comb begin
    strobes = '0;
    if (cmdWr) begin
      strobes.start   = (busWrData == CMD_START);
      strobes.stop    = (busWrData == CMD_STOP);
      strobes.refresh = (busWrData == CMD_REFRESH);
    end
    if (dataWr && decState == DEC_WAIT_DATA) begin
      strobes.regWr   = 1'b1;
      strobes.regIdx  = idxReg;
      strobes.regData = busWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decState  <= DEC_IDLE;
      idxReg    <= '0;
      probeFlag <= 1'b0;
    end else begin
      if (cmdWr) begin
        // any command byte abandons a pending indirect write
        decState  <= (busWrData == CMD_INDIRECT) ? DEC_WAIT_IDX : DEC_IDLE;
        probeFlag <= (busWrData == CMD_PROBE);
      end else begin
        if (dataRd) probeFlag <= 1'b0;
        if (dataWr) begin
          case (decState)
            DEC_WAIT_IDX: begin
              idxReg   <= busWrData;
              decState <= DEC_WAIT_DATA;
            end
            DEC_WAIT_DATA: decState <= DEC_IDLE;
            default:       decState <= DEC_IDLE;
          endcase
        end
      end
    end
  end

  assign busRdData = (dataRd && probeFlag) ? ID_VALUE : 8'h00;
endmodule

// File: rtl/portWdtDatapath.sv
module portWdtDatapath
  import portWdtPkg::*;
#(
  parameter int TICK_CYCLES       = 12_500_000,
  parameter int PULSE_CYCLES      = 16,
  parameter int DEFAULT_RST_TICKS = 600
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t strobes,
  output logic        sysReset,
  output wdtPhase_t   phase,
  output logic [15:0] rstDly
);
  localparam int DLY_W   = 16;
  localparam int TICK_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [TICK_W-1:0]  TICK_LAST  = TICK_W'(TICK_CYCLES - 1);
  localparam logic [PULSE_W-1:0] PULSE_LOAD = PULSE_W'(PULSE_CYCLES);

  logic [DLY_W-1:0]   armDly;
  logic [DLY_W-1:0]   dlyCnt;
  logic [TICK_W-1:0]  preCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               running;
  logic               tick;
  logic               startAcc;
  logic               refreshAcc;

  // indirect register file: byte-wide writes into two 16-bit delays
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armDly <= '0;
      rstDly <= DLY_W'(DEFAULT_RST_TICKS);
    end else if (strobes.regWr) begin
      case (strobes.regIdx)
        IDX_ARM_HI: armDly[15:8] <= strobes.regData;
        IDX_ARM_LO: armDly[7:0]  <= strobes.regData;
        IDX_RST_HI: rstDly[15:8] <= strobes.regData;
        IDX_RST_LO: rstDly[7:0]  <= strobes.regData;
        default: ;
      endcase
    end
  end

  assign running    = (phase == PH_ARMING) || (phase == PH_COUNTING);
  assign startAcc   = strobes.start && (phase == PH_STOPPED);
  assign refreshAcc = strobes.refresh && (phase == PH_COUNTING);
  assign tick       = running && (preCnt == TICK_LAST);

  // tick prescaler
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (startAcc || refreshAcc || !running || tick) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  // two-phase countdown and reset pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_STOPPED;
      dlyCnt   <= '0;
      pulseCnt <= '0;
    end else begin
      case (phase)
        PH_STOPPED: begin
          if (strobes.start) begin
            if (armDly == '0) begin
              phase  <= PH_COUNTING;
              dlyCnt <= rstDly;
            end else begin
              phase  <= PH_ARMING;
              dlyCnt <= armDly;
            end
          end
        end
        PH_ARMING: begin
          if (strobes.stop) phase <= PH_STOPPED;
          else if (tick) begin
            if (dlyCnt <= DLY_W'(1)) begin
              phase  <= PH_COUNTING;
              dlyCnt <= rstDly;
            end else dlyCnt <= dlyCnt - 1'b1;
          end
        end
        PH_COUNTING: begin
          if (strobes.stop) phase <= PH_STOPPED;
          else if (strobes.refresh) dlyCnt <= rstDly;
          else if (tick) begin
            if (dlyCnt <= DLY_W'(1)) begin
              phase    <= PH_FIRING;
              pulseCnt <= PULSE_LOAD;
            end else dlyCnt <= dlyCnt - 1'b1;
          end
        end
        default: begin
          if (pulseCnt <= PULSE_W'(1)) phase <= PH_STOPPED;
          else pulseCnt <= pulseCnt - 1'b1;
        end
      endcase
    end
  end

  assign sysReset = (phase == PH_FIRING);
endmodule

// File: rtl/portWatchdog.sv
module portWatchdog
  import portWdtPkg::*;
#(
  parameter int TICK_CYCLES       = 12_500_000,
  parameter int PULSE_CYCLES      = 16,
  parameter int DEFAULT_RST_TICKS = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       sysReset
);
  wdtStrobes_t strobes;
  wdtPhase_t   phaseW;
  logic [15:0] rstDlyW;

  portWdtCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .strobes   (strobes)
  );

  portWdtDatapath #(
    .TICK_CYCLES       (TICK_CYCLES),
    .PULSE_CYCLES      (PULSE_CYCLES),
    .DEFAULT_RST_TICKS (DEFAULT_RST_TICKS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sysReset (sysReset),
    .phase    (phaseW),
    .rstDly   (rstDlyW)
  );
endmodule

// File: rtl/portWdtChecker.sv
module portWdtChecker
  import portWdtPkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        sysReset,
  input wdtPhase_t   phase,
  input wdtStrobes_t str,
  input logic [15:0] rstDly
);
  logic [15:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN) hiCnt <= '0;
    else if (sysReset) hiCnt <= hiCnt + 1'b1;
    else hiCnt <= '0;
  end

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysReset) |-> hiCnt == 16'(PULSE_CYCLES));

  // R3
  fire_from_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysReset) |-> $past(phase) == PH_COUNTING);

  // R6
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.stop && (phase == PH_ARMING || phase == PH_COUNTING)) |=> phase == PH_STOPPED);

  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STOPPED && !str.start) |=> (phase == PH_STOPPED && !sysReset));

  // R2
  low_byte_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.regWr && str.regIdx == IDX_RST_LO) |=> rstDly[7:0] == $past(str.regData));
endmodule

bind portWatchdog portWdtChecker #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sysReset (sysReset),
  .phase    (phaseW),
  .str      (strobes),
  .rstDly   (rstDlyW)
);

// File: tb/portWatchdog_tb_top.sv
module portWatchdog_tb_top;
  localparam int T   = 4;
  localparam int P   = 3;
  localparam int DEF = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       sysReset;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  portWatchdog #(.TICK_CYCLES(T), .PULSE_CYCLES(P), .DEFAULT_RST_TICKS(DEF)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .sysReset(sysReset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic wrByte(input logic a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdByte(output logic [7:0] d);
    busAddr = 1'b0; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] val);
    wrByte(1'b1, 8'h89);
    wrByte(1'b0, idx);
    wrByte(1'b0, val);
  endtask

  task automatic setDelays(input int a, input int n);
    setReg(8'h58, 8'(a >> 8));
    setReg(8'h59, 8'(a));
    setReg(8'h5E, 8'(n >> 8));
    setReg(8'h5F, 8'(n));
  endtask

  task automatic measure(input int maxC, output int lat);
    lat = -1;
    for (int k = 1; k <= maxC; k++) begin
      @(negedge clk);
      if (sysReset) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic width(output int w);
    w = 1;
    while (sysReset) begin
      @(negedge clk);
      if (sysReset) w++;
    end
  endtask

  task automatic quiet(input int n, output bit saw);
    saw = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sysReset) saw = 1'b1;
    end
  endtask

  // start, then check latency and pulse width
  task automatic runAndCheck(input string req, input int expLat);
    int lat;
    int w;
    wrByte(1'b1, 8'h28);
    measure(expLat + 40, lat);
    chk(lat == expLat, req, lat, expLat);
    if (lat > 0) begin
      width(w);
      chk(w == P, "R7", w, P);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    bit saw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(sysReset == 1'b0, "R11", int'(sysReset), 0);
    // R1 no probe pending: data read is zero
    rdByte(rd);
    chk(rd == 8'h00, "R1", rd, 0);
    wrByte(1'b1, 8'h30);
    rdByte(rd);
    chk(rd == 8'h95, "R1", rd, 8'h95);
    rdByte(rd);
    chk(rd == 8'h00, "R1", rd, 0);

    // R11 default reset delay, zero arming delay
    runAndCheck("R11", DEF * T);

    // R3 / R4 sweep
    for (int a = 0; a <= 2; a++) begin
      for (int n = 0; n <= 4; n++) begin
        setDelays(a, n);
        runAndCheck(a == 0 ? "R3" : "R4", (a + (n == 0 ? 1 : n)) * T);
      end
    end

    // R2 high byte of reset delay takes effect
    setDelays(0, 258);
    runAndCheck("R2", 258 * T);
    setDelays(1, 2);
    setReg(8'h58, 8'h01);
    runAndCheck("R2", (257 + 2) * T);

    // R5 refresh reloads
    setDelays(0, 5);
    wrByte(1'b1, 8'h28);
    repeat (7) @(negedge clk);
    wrByte(1'b1, 8'h2A);
    measure(60, lat);
    chk(lat == 5 * T, "R5", lat, 5 * T);
    if (lat > 0) width(lat);

    // R6 stop while counting and while arming
    wrByte(1'b1, 8'h28);
    repeat (5) @(negedge clk);
    wrByte(1'b1, 8'h29);
    quiet(60, saw);
    chk(!saw, "R6", int'(saw), 0);
    setDelays(2, 3);
    wrByte(1'b1, 8'h28);
    repeat (3) @(negedge clk);
    wrByte(1'b1, 8'h29);
    quiet(60, saw);
    chk(!saw, "R6", int'(saw), 0);

    // R10 stop/refresh while stopped, registers retained
    wrByte(1'b1, 8'h29);
    wrByte(1'b1, 8'h2A);
    quiet(60, saw);
    chk(!saw, "R10", int'(saw), 0);
    runAndCheck("R10", 5 * T);

    // R7 no second pulse after expiry
    quiet(80, saw);
    chk(!saw, "R7", int'(saw), 0);

    // R8 abandoned indirect write
    setDelays(0, 2);
    wrByte(1'b1, 8'h89);
    wrByte(1'b0, 8'h5F);
    wrByte(1'b1, 8'h29);
    wrByte(1'b0, 8'h07);
    runAndCheck("R8", 2 * T);

    // R9 unknown index and unknown command
    setReg(8'h40, 8'h09);
    wrByte(1'b1, 8'h55);
    runAndCheck("R9", 2 * T);
    wrByte(1'b1, 8'h28);
    wrByte(1'b1, 8'h55);
    measure(40, lat);
    chk(lat == 2 * T - 1, "R9", lat, 2 * T - 1);
    if (lat > 0) width(lat);

    summary();
    $finish;
  end
endmodule